// File: doc/BRIEF.md
# Prioritized Exception Pending and Active Tracker

This block keeps a pending bit and an active bit for each exception a processor core can take: three fixed system exceptions (reset, non-maskable interrupt, hard fault) and a parameterized set of external interrupt lines. Each cycle it looks at every pending exception that is allowed to run. It picks the most urgent one and offers it to the core as a take request with an exception number. The core answers with an entry strobe when it starts the handler and with a return strobe, carrying the number, when the handler finishes.

External lines each have their own trigger mode: level, rising edge, falling edge, or a filtered edge that only counts once the line has stayed high for a programmed number of cycles. Each line also has a programmable priority and an enable bit. A global mask holds back every programmable line. Software strobes can set or clear each line's pending bit directly.

A pending exception is offered only if it is strictly more urgent than the most urgent handler already active. This is what allows nesting.

Top module: `exc_prio_tracker`

## Requirements
- R1: After reset is released, only the reset exception (number 1) is pending, nothing is active, and it is offered at once with `take_req_o` high and `take_num_o` = 1.
- R2: Urgency keys run 0 for reset, 1 for NMI (number 2), 2 for hard fault (number 3), and priority+3 for line k (number 16+k). The smallest key wins, and on equal keys the lower exception number wins.
- R3: The global mask has no effect on reset, NMI or hard fault; each is still offered while `gmask_i` is high.
- R4: While `gmask_i` is high, or while a line's `irq_en_i` bit is 0, that line is never offered. Its pending bit is kept.
- R5: An entry strobe while `take_req_o` is high clears the pending bit of `take_num_o` and sets its active bit in the next cycle.
- R6: A pending exception is offered only if its key is strictly lower than the lowest key among the active exceptions. An offered exception is always pending and not active.
- R7: A return strobe clears the active bit of `ret_num_i`. A level-mode line does not re-pend while its handler is active. If the line is still high when the return strobe arrives, it pends again in the same cycle.
- R8: A pending bit stays set after its request goes away, until it is entered or cleared by `sw_clr_i`. `sw_set_i` sets it, and `sw_clr_i` wins over any set in the same cycle.
- R9: The 2-bit mode field of line k (`irq_mode_i[2k+1:2k]`) selects the trigger: 0 = level, 1 = rising edge, 2 = falling edge, 3 = filtered. Edge-mode lines do not re-pend on return.
- R10: In filtered mode a line pends only once it has been high for FILT_CYC consecutive samples after going high. Shorter pulses leave it not pending.
- R11: A rising edge on `nmi_i` pends the NMI, and any cycle with `fault_i` high pends the hard fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_line_i | input | N_LINES | External request lines |
| irq_mode_i | input | 2*N_LINES | Trigger mode, 2 bits per line |
| irq_prio_i | input | N_LINES*PRIO_W | Programmable priority per line, smaller is more urgent |
| irq_en_i | input | N_LINES | Per-line enable |
| gmask_i | input | 1 | Global mask of programmable lines |
| sw_set_i | input | N_LINES | Software set-pending strobes |
| sw_clr_i | input | N_LINES | Software clear-pending strobes |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| fault_i | input | 1 | Hard fault request |
| entry_ack_i | input | 1 | Core starts the offered handler |
| ret_valid_i | input | 1 | Core returns from a handler |
| ret_num_i | input | NUM_W | Exception number being returned from |
| take_req_o | output | 1 | An exception is offered |
| take_num_o | output | NUM_W | Number of the offered exception |
| pend_o | output | 16+N_LINES | Pending bit per exception number |
| act_o | output | 16+N_LINES | Active bit per exception number |

## Verification
The bench builds the block with four lines, 3-bit priorities and a three-cycle filter. Four lines are enough to set up priority ties, two-level nesting and a blocked lower-priority line all at once. The short filter window lets both a rejected two-cycle glitch and an accepted three-cycle pulse be checked cycle by cycle. The random phase draws all four priorities, the enables and the mask together, so winner selection is exercised across ties and fully disabled sets.

// File: rtl/exc_trk_pkg.sv
package exc_trk_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_RISE  = 2'd1,
        TRIG_FALL  = 2'd2,
        TRIG_FILT  = 2'd3
    } trig_e;

    localparam int unsigned EXC_RESET = 1;
    localparam int unsigned EXC_NMI   = 2;
    localparam int unsigned EXC_FAULT = 3;
    localparam int unsigned EXC_LINE0 = 16;
    localparam int unsigned FIXED_CNT = 3;

endpackage

// File: rtl/exc_line_detect.sv
module exc_line_detect
    import exc_trk_pkg::*;
#(
    parameter int unsigned FILT_CYC = 3,
    localparam int unsigned CNT_W   = $clog2(FILT_CYC + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  line_i,
    input  trig_e mode_i,
    output logic  level_o,
    output logic  event_o
);

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = line_i;
        if (!line_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_W'(FILT_CYC)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        level_o = (mode_i == TRIG_LEVEL) && line_i;
        unique case (mode_i)
            TRIG_RISE: event_o = line_i && !st_q.prev;
            TRIG_FALL: event_o = !line_i && st_q.prev;
            TRIG_FILT: event_o = line_i && (st_q.cnt == CNT_W'(FILT_CYC - 1));
            default:   event_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/exc_select.sv
module exc_select #(
    parameter int unsigned NEXC  = 20,
    parameter int unsigned KEY_W = 5,
    parameter int unsigned NUM_W = 5
) (
    input  logic [NEXC-1:0]       cand_i,
    input  logic [NEXC-1:0]       act_i,
    input  logic [NEXC*KEY_W-1:0] keys_i,
    output logic                  take_o,
    output logic [NUM_W-1:0]      num_o
);

    logic [KEY_W-1:0] best_key;
    logic [KEY_W-1:0] run_key;
    logic             found;

    always_comb begin
        best_key = '1;
        run_key  = '1;
        found    = 1'b0;
        num_o    = '0;
        for (int i = 0; i < NEXC; i++) begin
            if (cand_i[i] && (!found || keys_i[i*KEY_W +: KEY_W] < best_key)) begin
                found    = 1'b1;
                best_key = keys_i[i*KEY_W +: KEY_W];
                num_o    = NUM_W'(i);
            end
            if (act_i[i] && keys_i[i*KEY_W +: KEY_W] < run_key) begin
                run_key = keys_i[i*KEY_W +: KEY_W];
            end
        end
        take_o = found && (best_key < run_key);
    end

endmodule

// File: rtl/exc_prio_tracker.sv
module exc_prio_tracker
    import exc_trk_pkg::*;
#(
    parameter int unsigned N_LINES  = 4,
    parameter int unsigned PRIO_W   = 3,
    parameter int unsigned FILT_CYC = 3,
    localparam int unsigned NEXC    = EXC_LINE0 + N_LINES,
    localparam int unsigned NUM_W   = $clog2(NEXC),
    localparam int unsigned KEY_W   = PRIO_W + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LINES-1:0]        irq_line_i,
    input  logic [2*N_LINES-1:0]      irq_mode_i,
    input  logic [N_LINES*PRIO_W-1:0] irq_prio_i,
    input  logic [N_LINES-1:0]        irq_en_i,
    input  logic                      gmask_i,
    input  logic [N_LINES-1:0]        sw_set_i,
    input  logic [N_LINES-1:0]        sw_clr_i,
    input  logic                      nmi_i,
    input  logic                      fault_i,
    input  logic                      entry_ack_i,
    input  logic                      ret_valid_i,
    input  logic [NUM_W-1:0]          ret_num_i,
    output logic                      take_req_o,
    output logic [NUM_W-1:0]          take_num_o,
    output logic [NEXC-1:0]           pend_o,
    output logic [NEXC-1:0]           act_o
);

    typedef struct packed {
        logic [NEXC-1:0] pend;
        logic [NEXC-1:0] act;
        logic            nmi_prev;
    } trk_t;

    trk_t st_d, st_q;

    logic [N_LINES-1:0]    line_lvl;
    logic [N_LINES-1:0]    line_evt;
    logic [NEXC-1:0]       elig;
    logic [NEXC*KEY_W-1:0] keys;
    logic                  take;
    logic [NUM_W-1:0]      take_num;

    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        exc_line_detect #(
            .FILT_CYC (FILT_CYC)
        ) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (irq_line_i[k]),
            .mode_i  (trig_e'(irq_mode_i[2*k +: 2])),
            .level_o (line_lvl[k]),
            .event_o (line_evt[k])
        );
    end

    always_comb begin
        keys = '1;
        elig = '0;
        keys[EXC_RESET*KEY_W +: KEY_W] = KEY_W'(0);
        keys[EXC_NMI*KEY_W   +: KEY_W] = KEY_W'(1);
        keys[EXC_FAULT*KEY_W +: KEY_W] = KEY_W'(2);
        elig[EXC_RESET] = 1'b1;
        elig[EXC_NMI]   = 1'b1;
        elig[EXC_FAULT] = 1'b1;
        for (int k = 0; k < N_LINES; k++) begin
            keys[(EXC_LINE0+k)*KEY_W +: KEY_W] =
                KEY_W'(irq_prio_i[k*PRIO_W +: PRIO_W]) + KEY_W'(FIXED_CNT);
            elig[EXC_LINE0+k] = irq_en_i[k] && !gmask_i;
        end
    end

    exc_select #(
        .NEXC  (NEXC),
        .KEY_W (KEY_W),
        .NUM_W (NUM_W)
    ) u_sel (
        .cand_i (st_q.pend & elig),
        .act_i  (st_q.act),
        .keys_i (keys),
        .take_o (take),
        .num_o  (take_num)
    );

    always_comb begin
        st_d          = st_q;
        st_d.nmi_prev = nmi_i;

        if (nmi_i && !st_q.nmi_prev) begin
            st_d.pend[EXC_NMI] = 1'b1;
        end
        if (fault_i) begin
            st_d.pend[EXC_FAULT] = 1'b1;
        end

        for (int k = 0; k < N_LINES; k++) begin
            if (line_evt[k] || sw_set_i[k] ||
                (line_lvl[k] && (!st_q.act[EXC_LINE0+k] ||
                 (ret_valid_i && ret_num_i == NUM_W'(EXC_LINE0+k))))) begin
                st_d.pend[EXC_LINE0+k] = 1'b1;
            end
            if (sw_clr_i[k]) begin
                st_d.pend[EXC_LINE0+k] = 1'b0;
            end
        end

        for (int i = 0; i < NEXC; i++) begin
            if (ret_valid_i && ret_num_i == NUM_W'(i)) begin
                st_d.act[i] = 1'b0;
            end
            if (entry_ack_i && take && take_num == NUM_W'(i)) begin
                st_d.pend[i] = 1'b0;
                st_d.act[i]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q                <= '0;
            st_q.pend[EXC_RESET] <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_req_o = take;
    assign take_num_o = take_num;
    assign pend_o     = st_q.pend;
    assign act_o      = st_q.act;

endmodule

// File: rtl/exc_prio_tracker_chk.sv
module exc_prio_tracker_chk #(
    parameter int unsigned N_LINES  = 4,
    parameter int unsigned PRIO_W   = 3,
    parameter int unsigned FILT_CYC = 3,
    localparam int unsigned NEXC    = 16 + N_LINES,
    localparam int unsigned NUM_W   = $clog2(NEXC)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_LINES-1:0]        irq_line_i,
    input logic [2*N_LINES-1:0]      irq_mode_i,
    input logic [N_LINES*PRIO_W-1:0] irq_prio_i,
    input logic [N_LINES-1:0]        irq_en_i,
    input logic                      gmask_i,
    input logic [N_LINES-1:0]        sw_set_i,
    input logic [N_LINES-1:0]        sw_clr_i,
    input logic                      nmi_i,
    input logic                      fault_i,
    input logic                      entry_ack_i,
    input logic                      ret_valid_i,
    input logic [NUM_W-1:0]          ret_num_i,
    input logic                      take_req_o,
    input logic [NUM_W-1:0]          take_num_o,
    input logic [NEXC-1:0]           pend_o,
    input logic [NEXC-1:0]           act_o
);

    a_r5_entry_moves_to_active: assert property (@(posedge clk) disable iff (!rst_n)
        entry_ack_i && take_req_o |=>
            act_o[$past(take_num_o)] && !pend_o[$past(take_num_o)]);

    a_r6_offer_is_pending_idle: assert property (@(posedge clk) disable iff (!rst_n)
        take_req_o |-> pend_o[take_num_o] && !act_o[take_num_o]);

    a_r3_nmi_not_maskable: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o[2] && !act_o[1] && !act_o[2] |-> take_req_o);

    a_r4_mask_holds_lines: assert property (@(posedge clk) disable iff (!rst_n)
        gmask_i && take_req_o |-> take_num_o < NUM_W'(16));

    a_r7_return_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid_i && ret_num_i < NUM_W'(NEXC) &&
        !(entry_ack_i && take_req_o && take_num_o == ret_num_i)
            |=> !act_o[$past(ret_num_i)]);

endmodule

bind exc_prio_tracker exc_prio_tracker_chk #(
    .N_LINES  (N_LINES),
    .PRIO_W   (PRIO_W),
    .FILT_CYC (FILT_CYC)
) u_chk (.*);

// File: tb/tb_exc_prio_tracker.sv
`timescale 1ns/1ps
module tb_exc_prio_tracker;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  line = '0, en = 4'hF, sset = '0, sclr = '0;
    logic [7:0]  mode = '0;
    logic [11:0] prio = '0;
    logic        gmask = 1'b0, nmi = 1'b0, fault = 1'b0, eack = 1'b0, rv = 1'b0;
    logic [4:0]  rnum = '0;
    logic        take;
    logic [4:0]  tnum;
    logic [19:0] pend, act;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    exc_prio_tracker #(.N_LINES(N), .PRIO_W(3), .FILT_CYC(3)) dut (
        .clk(clk), .rst_n(rst_n), .irq_line_i(line), .irq_mode_i(mode),
        .irq_prio_i(prio), .irq_en_i(en), .gmask_i(gmask), .sw_set_i(sset),
        .sw_clr_i(sclr), .nmi_i(nmi), .fault_i(fault), .entry_ack_i(eack),
        .ret_valid_i(rv), .ret_num_i(rnum), .take_req_o(take),
        .take_num_o(tnum), .pend_o(pend), .act_o(act)
    );

    task automatic chk(input string req, input int actual, input int expv);
        checks++;
        if (actual != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic enter();
        eack = 1'b1;
        tick();
        eack = 1'b0;
        #1;
    endtask

    task automatic retn(input int n);
        rv = 1'b1;
        rnum = 5'(n);
        tick();
        rv = 1'b0;
        #1;
    endtask

    function automatic int exp_win(input logic [11:0] p, input logic [3:0] e, input logic g);
        int best = -1;
        int bp = 99;
        for (int k = 0; k < N; k++) begin
            if (e[k] && !g && int'(p[k*3 +: 3]) < bp) begin
                bp = int'(p[k*3 +: 3]);
                best = 16 + k;
            end
        end
        return best;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 pend", int'(pend), 2);
        chk("R1 act", int'(act), 0);
        chk("R1 take", int'(take), 1);
        chk("R1 num", int'(tnum), 1);
        enter();
        chk("R5 reset active", int'(act), 2);
        chk("R5 reset unpended", int'(pend), 0);
        // R11 / R6: NMI pends while reset handler runs, no preemption
        gmask = 1'b1;
        nmi = 1'b1;
        tick();
        chk("R11 nmi pend", int'(pend[2]), 1);
        chk("R6 no preempt of reset", int'(take), 0);
        fault = 1'b1;
        tick();
        fault = 1'b0;
        chk("R11 fault pend", int'(pend[3]), 1);
        retn(1);
        chk("R2 nmi over fault", int'(tnum), 2);
        chk("R3 nmi under gmask", int'(take), 1);
        enter();
        chk("R6 fault waits", int'(take), 0);
        retn(2);
        chk("R3 fault under gmask take", int'(take), 1);
        chk("R3 fault num", int'(tnum), 3);
        enter();
        retn(3);
        nmi = 1'b0;
        chk("R7 all idle", int'(act), 0);
        chk("R8 none pending", int'(pend), 0);
        // R8 / R4 software set and clear under mask
        prio = {3'd6, 3'd2, 3'd2, 3'd5};
        sset = 4'hF;
        tick();
        sset = 4'h0;
        chk("R8 sw set", int'(pend[19:16]), 15);
        chk("R4 gmask blocks", int'(take), 0);
        sset = 4'b0010;
        sclr = 4'b0110;
        tick();
        sset = 4'h0;
        sclr = 4'h0;
        chk("R8 clr wins", int'(pend[19:16]), 9);
        gmask = 1'b0;
        #1;
        chk("R2 lowest prio wins", int'(tnum), 16);
        enter();
        chk("R6 lower prio held", int'(take), 0);
        sset = 4'b0010;
        tick();
        sset = 4'h0;
        chk("R6 preempt take", int'(take), 1);
        chk("R6 preempt num", int'(tnum), 17);
        enter();
        chk("R5 nested active", int'(act[17:16]), 3);
        retn(17);
        chk("R6 still blocked by line0", int'(take), 0);
        retn(16);
        chk("R7 line3 after returns", int'(tnum), 19);
        en = 4'b0111;
        #1;
        chk("R4 disabled not offered", int'(take), 0);
        chk("R4 pending kept", int'(pend[19]), 1);
        en = 4'hF;
        sclr = 4'b1000;
        tick();
        sclr = 4'h0;
        chk("R8 sw clear", int'(pend), 0);
        sset = 4'b0110;
        tick();
        sset = 4'h0;
        chk("R2 tie lower number", int'(tnum), 17);
        sclr = 4'b0110;
        tick();
        sclr = 4'h0;
        // R7 level mode
        line[0] = 1'b1;
        tick();
        chk("R9 level pend", int'(pend[16]), 1);
        enter();
        chk("R5 level entered", int'(pend[16]), 0);
        tick();
        chk("R7 no repend while active", int'(pend[16]), 0);
        retn(16);
        chk("R7 repend on return", int'(pend[16]), 1);
        chk("R7 active cleared", int'(act[16]), 0);
        line[0] = 1'b0;
        tick();
        chk("R8 sticky", int'(pend[16]), 1);
        enter();
        retn(16);
        chk("R7 no repend when low", int'(pend[16]), 0);
        // R9 rising edge
        mode = 8'b11_10_01_00;
        line[1] = 1'b1;
        tick();
        chk("R9 rise pend", int'(pend[17]), 1);
        enter();
        retn(17);
        chk("R9 edge no repend", int'(pend[17]), 0);
        line[1] = 1'b0;
        tick();
        // R9 falling edge
        line[2] = 1'b1;
        tick();
        chk("R9 fall ignores rise", int'(pend[18]), 0);
        line[2] = 1'b0;
        tick();
        chk("R9 fall pend", int'(pend[18]), 1);
        sclr = 4'b0100;
        tick();
        sclr = 4'h0;
        // R10 filtered
        line[3] = 1'b1;
        tick();
        tick();
        line[3] = 1'b0;
        tick();
        chk("R10 glitch rejected", int'(pend[19]), 0);
        line[3] = 1'b1;
        tick();
        tick();
        chk("R10 not yet", int'(pend[19]), 0);
        tick();
        chk("R10 accepted", int'(pend[19]), 1);
        line[3] = 1'b0;
        sclr = 4'b1000;
        tick();
        sclr = 4'h0;
        mode = 8'h00;
        // R2 / R4 random priorities, enables and mask
        for (int r = 0; r < 40; r++) begin
            int w;
            prio = 12'($urandom);
            en = 4'($urandom);
            gmask = ($urandom % 4) == 0;
            sset = 4'hF;
            tick();
            sset = 4'h0;
            w = exp_win(prio, en, gmask);
            chk("R4 random take", int'(take), (w >= 0) ? 1 : 0);
            if (w >= 0) chk("R2 random winner", int'(tnum), w);
            sclr = 4'hF;
            tick();
            sclr = 4'h0;
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule